// File: doc/BRIEF.md
# Parallel Operation Write-Back Merger

This block sits beside a register file in a processor that runs a main instruction and a small auxiliary operation in the same step. Both operations read the same starting register state. The auxiliary results are not written right away: they are held as up to four pending (register index, value) entries until the main operation is done.

Write-back happens in two phases. The first is a zero phase, requested after the main operation has read its operands and before it writes anything. In this phase every register named by a valid pending entry is forced to zero. The second is a merge phase, requested after the main operation's own writes. In this phase each targeted register is rewritten as its current contents ORed with the pending values. The buffer then empties.

Because the target was zeroed first, the final value works out in one of two ways. If the main operation did not touch the register, it ends up holding just the auxiliary result. If both operations wrote it, it ends up holding the OR of the two. The block drives one write port per slot and reads the current register contents through a matching read port per slot. When several slots name the same register, only the highest-numbered of them writes, so the ports never collide.

Top module: `opwb_merge`

## Requirements
- R1: After reset the buffer holds no valid entry, so a zero or merge request produces no write enable until entries are captured.
- R2: `cap_en` loads all slots (valid bits, indices, values) at the clock edge. While neither `zero_go` nor `merge_go` is high, every `wb_we` bit is 0 and the stored entries hold.
- R3: While `zero_go` is high and `merge_go` is low, each valid slot drives its register index on `wb_idx` with data 0 and its write enable set, in the same cycle.
- R4: While `merge_go` is high, each writing slot drives `rf_rdata` of its slot ORed with the pending value(s) for that register.
- R5: The clock edge at which `merge_go` is high (and `cap_en` low) empties the buffer, so a later zero or merge request writes nothing.
- R6: When several valid slots name the same register, only the highest-numbered of them asserts its write enable. Its data is the OR of all those slots' values, so the merge accumulates in slot order 0 to 3.
- R7: With no valid slot, a zero or merge request leaves every register exactly as the main operation left it.
- R8: When `zero_go` and `merge_go` are high together, the merge behaviour applies.
- R9: A slot whose valid bit is 0 is neither zeroed nor merged, whatever index and value it carries.
- R10: Over a full step (capture, zero, main write, merge), a register written only by the auxiliary operation ends at the auxiliary value. One written by both ends at the OR of both. One written only by the main operation keeps the main value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Load the pending buffer from the capture inputs |
| cap_valid | input | NSLOT | Valid bit per slot; bit j is slot j |
| cap_idx | input | NSLOT*IW | Register index per slot; slot j at bits [j*IW +: IW] |
| cap_data | input | NSLOT*DW | Auxiliary result per slot; slot j at bits [j*DW +: DW] |
| zero_go | input | 1 | Request the zero phase |
| merge_go | input | 1 | Request the merge phase and empty the buffer |
| rf_rdata | input | NSLOT*DW | Current contents of the register at wb_idx slot j |
| wb_we | output | NSLOT | Write enable per slot |
| wb_idx | output | NSLOT*IW | Register index per slot, used for both read and write |
| wb_data | output | NSLOT*DW | Write data per slot |

## Verification
Capture takes one clock edge. From the next cycle on, the write-port outputs follow `zero_go`, `merge_go` and `rf_rdata` combinationally. The bench therefore drives each request just after a falling edge and samples the ports one time unit later, within the same cycle. The bench keeps its own register-file model, which takes the block's writes at the rising edge. Final register contents are compared at the falling edge after the merge edge. The emptying after a merge is checked in the cycle after that edge, by asserting `merge_go` again and expecting no write enable.

// File: rtl/opwb_merge.sv
module opwb_merge #(
  parameter int NSLOT = 4,
  parameter int IW    = 3,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [NSLOT-1:0]    cap_valid,
  input  logic [NSLOT*IW-1:0] cap_idx,
  input  logic [NSLOT*DW-1:0] cap_data,
  input  logic                zero_go,
  input  logic                merge_go,
  input  logic [NSLOT*DW-1:0] rf_rdata,
  output logic [NSLOT-1:0]    wb_we,
  output logic [NSLOT*IW-1:0] wb_idx,
  output logic [NSLOT*DW-1:0] wb_data
);

  logic [NSLOT-1:0] vld_q;
  logic [IW-1:0]    idx_q [NSLOT];
  logic [DW-1:0]    dat_q [NSLOT];
  logic [DW-1:0]    acc   [NSLOT];
  logic [NSLOT-1:0] shadowed;

  wire go = zero_go | merge_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int j = 0; j < NSLOT; j++) begin
        idx_q[j] <= '0;
        dat_q[j] <= '0;
      end
    end else if (cap_en) begin
      vld_q <= cap_valid;
      for (int j = 0; j < NSLOT; j++) begin
        idx_q[j] <= cap_idx[j*IW +: IW];
        dat_q[j] <= cap_data[j*DW +: DW];
      end
    end else if (merge_go) begin
      vld_q <= '0;
    end
  end

  always_comb begin
    for (int j = 0; j < NSLOT; j++) begin
      acc[j]      = '0;
      shadowed[j] = 1'b0;
      for (int k = 0; k < NSLOT; k++) begin
        if (vld_q[k] && idx_q[k] == idx_q[j]) begin
          acc[j] = acc[j] | dat_q[k];
          if (k > j) shadowed[j] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NSLOT; j++) begin
      wb_we[j]             = go & vld_q[j] & ~shadowed[j];
      wb_idx[j*IW +: IW]   = idx_q[j];
      wb_data[j*DW +: DW]  = merge_go ? (rf_rdata[j*DW +: DW] | acc[j]) : '0;
    end
  end

endmodule

// File: rtl/opwb_merge_chk.sv
module opwb_merge_chk #(
  parameter int NSLOT = 4,
  parameter int IW    = 3,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cap_en,
  input logic                zero_go,
  input logic                merge_go,
  input logic [NSLOT*DW-1:0] rf_rdata,
  input logic [NSLOT-1:0]    wb_we,
  input logic [NSLOT*IW-1:0] wb_idx,
  input logic [NSLOT*DW-1:0] wb_data
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_go && !merge_go) |-> wb_we == '0); // R2

  AST_ENTRIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !merge_go) |=> $stable(wb_idx)); // R2

  AST_EMPTY_AFTER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_go && !cap_en) |=> wb_we == '0); // R5

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_go && !merge_go && wb_we[j]) |-> wb_data[j*DW +: DW] == '0); // R3

    AST_MERGE_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_go && wb_we[j]) |->
        (wb_data[j*DW +: DW] & rf_rdata[j*DW +: DW]) == rf_rdata[j*DW +: DW]); // R4
  end

endmodule

bind opwb_merge opwb_merge_chk #(.NSLOT(NSLOT), .IW(IW), .DW(DW)) u_chk (.*);

// File: tb/opwb_merge_bench.sv
module opwb_merge_bench;
  localparam int P     = 10;
  localparam int NSLOT = 4;
  localparam int IW    = 3;
  localparam int DW    = 16;
  localparam int NREG  = 8;
  localparam logic [DW-1:0] SEED = 16'hF0F0;

  logic clk = 0, rst_n = 0;
  logic cap_en = 0, zero_go = 0, merge_go = 0;
  logic [NSLOT-1:0]    cap_valid = '0;
  logic [NSLOT*IW-1:0] cap_idx = '0;
  logic [NSLOT*DW-1:0] cap_data = '0;
  logic [NSLOT*DW-1:0] rf_rdata;
  logic [NSLOT-1:0]    wb_we;
  logic [NSLOT*IW-1:0] wb_idx;
  logic [NSLOT*DW-1:0] wb_data;

  logic [DW-1:0] rf [NREG];
  logic          seed = 0, main_we = 0;
  logic [IW-1:0] main_idx = '0;
  logic [DW-1:0] main_val = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(P/2) clk = ~clk;

  opwb_merge #(.NSLOT(NSLOT), .IW(IW), .DW(DW)) u_opwb_merge (.*);

  always_comb
    for (int j = 0; j < NSLOT; j++) rf_rdata[j*DW +: DW] = rf[wb_idx[j*IW +: IW]];

  always @(posedge clk) begin
    if (seed) for (int i = 0; i < NREG; i++) rf[i] <= SEED;
    if (main_we) rf[main_idx] <= main_val;
    for (int j = 0; j < NSLOT; j++)
      if (wb_we[j]) rf[wb_idx[j*IW +: IW]] <= wb_data[j*DW +: DW];
  end

  typedef struct packed {
    logic [3:0]  v;
    logic [11:0] idx;
    logic [63:0] dat;
    logic        men;
    logic [2:0]  midx;
    logic [15:0] mval;
    logic [2:0]  cidx;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{4'b0001, {3'd0,3'd0,3'd0,3'd2}, {16'h0,16'h0,16'h0,16'h0012},       1'b0, 3'd0, 16'h0,    3'd2, 16'h0012}, // R10 aux only
    '{4'b0010, {3'd0,3'd0,3'd5,3'd0}, {16'h0,16'h0,16'h0300,16'h0},       1'b1, 3'd5, 16'h4001, 3'd5, 16'h4301}, // R10 both
    '{4'b1001, {3'd1,3'd0,3'd0,3'd1}, {16'h0100,16'h0,16'h0,16'h0001},    1'b0, 3'd0, 16'h0,    3'd1, 16'h0101}, // R6 dup
    '{4'b1111, {3'd7,3'd4,3'd3,3'd0}, {16'h8,16'h4,16'h2,16'h1},          1'b1, 3'd4, 16'h8000, 3'd4, 16'h8004}, // R4 all slots
    '{4'b0000, {3'd6,3'd6,3'd6,3'd6}, {64'hFFFF_FFFF_FFFF_FFFF},          1'b0, 3'd0, 16'h0,    3'd6, 16'hF0F0}, // R7 none valid
    '{4'b0001, {3'd0,3'd3,3'd0,3'd7}, {16'h0,16'h00FF,16'h0,16'h0A00},    1'b0, 3'd0, 16'h0,    3'd3, 16'hF0F0}, // R9 invalid slot
    '{4'b0001, {3'd0,3'd0,3'd0,3'd2}, {16'h0,16'h0,16'h0,16'h0020},       1'b1, 3'd0, 16'h5555, 3'd0, 16'h5555}, // R10 main only
    '{4'b0011, {3'd0,3'd0,3'd2,3'd2}, {16'h0,16'h0,16'h0400,16'h0003},    1'b1, 3'd2, 16'h0800, 3'd2, 16'h0C03}  // R6 R10 dup plus main
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic capture(input logic [3:0] v, input logic [11:0] ix, input logic [63:0] d);
    @(negedge clk);
    seed = 1; cap_en = 1; cap_valid = v; cap_idx = ix; cap_data = d;
    @(negedge clk);
    seed = 0; cap_en = 0;
  endtask

  initial begin
    #(P*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    zero_go = 1; merge_go = 1; #1;
    check(wb_we == '0, "R1 reset empty", wb_we, 0);
    zero_go = 0; merge_go = 0;

    for (int i = 0; i < NVEC; i++) begin
      capture(VEC[i].v, VEC[i].idx, VEC[i].dat);
      zero_go = 1;
      @(negedge clk);
      zero_go = 0;
      main_we = VEC[i].men; main_idx = VEC[i].midx; main_val = VEC[i].mval;
      @(negedge clk);
      main_we = 0; merge_go = 1;
      @(negedge clk);
      check(rf[VEC[i].cidx] == VEC[i].exp, $sformatf("R4 R6 R7 R9 R10 vector %0d", i),
            rf[VEC[i].cidx], VEC[i].exp);
      #1;
      check(wb_we == '0, $sformatf("R5 empty after merge vector %0d", i), wb_we, 0);
      merge_go = 0;
    end

    // R2: captured entries cause no write without a request
    capture(4'b0101, {3'd0,3'd6,3'd0,3'd3}, {16'h0,16'h0077,16'h0,16'h0011});
    #1;
    check(wb_we == '0, "R2 idle no write", wb_we, 0);
    check(wb_idx[0 +: IW] == 3'd3 && wb_idx[2*IW +: IW] == 3'd6, "R2 indices held", wb_idx, 12'h183);

    // R3: zero phase drives zeros to valid slots only (R9)
    zero_go = 1; #1;
    check(wb_we == 4'b0101, "R3 zero enables", wb_we, 4'b0101);
    check(wb_data[0 +: DW] == '0 && wb_data[2*DW +: DW] == '0, "R3 zero data",
          {wb_data[2*DW +: DW], wb_data[0 +: DW]}, 0);

    // R8: merge wins when both requested
    merge_go = 1; #1;
    check(wb_data[0 +: DW] == 16'hF0F1, "R8 merge priority data", wb_data[0 +: DW], 16'hF0F1);
    check(wb_data[2*DW +: DW] == 16'hF0F7, "R8 merge priority slot2", wb_data[2*DW +: DW], 16'hF0F7);
    @(negedge clk);
    zero_go = 0; #1;
    check(wb_we == '0, "R5 buffer emptied", wb_we, 0);
    merge_go = 0;
    check(rf[3] == 16'hF0F1 && rf[6] == 16'hF0F7, "R8 registers merged", {rf[6], rf[3]}, 32'hF0F7_F0F1);

    // R6: duplicate index writes through one slot only
    capture(4'b0111, {3'd0,3'd4,3'd4,3'd4}, {16'h0,16'h0004,16'h0002,16'h0001});
    merge_go = 1; #1;
    check(wb_we == 4'b0100, "R6 single writer", wb_we, 4'b0100);
    check(wb_data[2*DW +: DW] == 16'hF0F7, "R6 accumulated data", wb_data[2*DW +: DW], 16'hF0F7);
    @(negedge clk);
    merge_go = 0;

    finish_run();
  end
endmodule